// File: doc/BRIEF.md
# Write-Only I2C Target Receiver

This block is the bus front end of a display controller that only ever receives. It brings the two I2C lines into the system clock domain and finds START and STOP conditions in them. It collects the first byte of each transfer and compares its upper seven bits with a fixed address. The lowest of those seven bits comes from a strap input, so two controllers on one bus can be told apart. The block never sends data. Its only drive onto SDA is an open-drain pull-down in the acknowledge slot. Each data byte it accepts after a matching write address is handed to downstream logic with a one-cycle strobe.

A transfer with a read address, or with an address for the other strap setting, is ignored completely. The block stays silent until the next START. Three further strap inputs are passed through as a hardware subaddress. Downstream command logic uses it to pick out one device among several that share a bus address.

Top module: `i2c_wo_target`

## Requirements
- R1: The first byte after a START is taken MSB first. Its bits 7..1 are the target address, and bit 0 is R/W (0 = write). The block acknowledges that byte only when bits 7..1 equal 011100 followed by the level of `sa0_i`, and bit 0 is 0. With `sa0_i`=0 the accepted byte is 0x70, and with `sa0_i`=1 it is 0x72.
- R2: An address byte with R/W=1 is never acknowledged, and no later byte of that transfer is acknowledged or output.
- R3: SDA is only ever pulled low, through `sda_oe_o`=1, and only in the acknowledge slot of an accepted byte. The pull-down starts at the SCL falling edge that ends bit 8 and ends at the SCL falling edge that ends the ninth clock. SDA is therefore low for the whole high phase of the ninth clock.
- R4: After an address byte that does not match, nothing is acknowledged or output until the next START. A repeated START that carries a matching address is served normally.
- R5: Once the address is accepted, every following 8-bit byte is acknowledged. The byte appears on `rx_data_o` (MSB first on the bus) together with a `rx_valid_o` pulse that lasts exactly one clock.
- R6: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A STOP returns the block to idle with SDA released. A START at any point, including a repeated START, begins a new address byte.
- R7: A START in the middle of a data byte discards the partial byte, which is never output.
- R8: `subaddr_o` always equals the strap input `strap_sub_i`.
- R9: During and right after reset, `sda_oe_o`=0 and `rx_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| sa0_i | input | 1 | Strap for the lowest address bit |
| strap_sub_i | input | 3 | Hardware subaddress straps |
| subaddr_o | output | 3 | Subaddress passed through |
| rx_data_o | output | 8 | Received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |

## Verification
Directed transfers are sent with the address byte set to 0x70, 0x71, 0x72 and 0x73 under both strap levels. This separates a correct address match from a match that drops the R/W bit or ignores the strap. Repeated STARTs that switch from a rejected address to an accepted one, and the reverse, show that the ignore state lasts until the next START and no longer. A START cut into the fifth bit of a data byte shows that partial bytes are dropped. Random transfers, with random addresses (biased toward the four near misses), random strap levels and one to four data bytes, are compared against a bench model of the acknowledge decision and of the received byte stream.

// File: rtl/i2c_wo_pkg.sv
package i2c_wo_pkg;

   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_ADDR     = 3'd1,
      ST_ADDR_ACK = 3'd2,
      ST_DATA     = 3'd3,
      ST_DATA_ACK = 3'd4,
      ST_IGNORE   = 3'd5
   } wo_state_e;

   localparam int unsigned WO_BYTE_W = 8;

endpackage

// File: rtl/i2c_wo_sync.sv
module i2c_wo_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_wo_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RESET_VAL;
            else        chain[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= RESET_VAL;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];

endmodule

// File: rtl/i2c_wo_cond.sv
module i2c_wo_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s_i;
         sda_q <= sda_s_i;
      end
   end

   logic scl_held_high;
   assign scl_held_high = scl_s_i & scl_q;

   assign scl_rise_o = scl_s_i & ~scl_q;
   assign scl_fall_o = ~scl_s_i & scl_q;
   assign start_o    = scl_held_high & sda_q & ~sda_s_i;
   assign stop_o     = scl_held_high & ~sda_q & sda_s_i;

endmodule

// File: rtl/i2c_wo_addr_match.sv
module i2c_wo_addr_match #(
   parameter int unsigned         BYTE_W      = 8,
   parameter logic [BYTE_W-3:0]   ADDR_PREFIX = 6'b011100
) (
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              sel_i,
   output logic              hit_o
);

   if (BYTE_W < 3) begin : g_bad_width
      $error("i2c_wo_addr_match: BYTE_W must be at least 3");
   end

   localparam int unsigned ADDR_W = BYTE_W - 1;

   logic [ADDR_W-1:0] own_addr;
   logic              is_write;

   assign own_addr = {ADDR_PREFIX, sel_i};
   assign is_write = ~byte_i[0];
   assign hit_o    = is_write & (byte_i[BYTE_W-1:1] == own_addr);

endmodule

// File: rtl/i2c_wo_target.sv
module i2c_wo_target #(
   parameter int unsigned               SYNC_STAGES = 2,
   parameter int unsigned               SUB_W       = 3,
   parameter bit                        SUB_REG     = 1'b0,
   parameter logic [i2c_wo_pkg::WO_BYTE_W-3:0] ADDR_PREFIX = 6'b011100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_o,
   input  logic             sa0_i,
   input  logic [SUB_W-1:0] strap_sub_i,
   output logic [SUB_W-1:0] subaddr_o,
   output logic [i2c_wo_pkg::WO_BYTE_W-1:0] rx_data_o,
   output logic             rx_valid_o
);
   import i2c_wo_pkg::*;

   localparam int unsigned BYTE_W = WO_BYTE_W;
   localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

   if (SUB_W < 1) begin : g_bad_sub
      $error("i2c_wo_target: SUB_W must be at least 1");
   end

   // line synchronisers
   logic scl_s;
   logic sda_s;

   i2c_wo_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
   );
   i2c_wo_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
   );

   // bus events
   logic scl_rise_ev;
   logic scl_fall_ev;
   logic start_ev;
   logic stop_ev;

   i2c_wo_cond u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s_i   (scl_s),
      .sda_s_i   (sda_s),
      .scl_rise_o(scl_rise_ev),
      .scl_fall_o(scl_fall_ev),
      .start_o   (start_ev),
      .stop_o    (stop_ev)
   );

   // receive state
   wo_state_e          st;
   logic [CNT_W-1:0]   bit_cnt;
   logic [BYTE_W-1:0]  shreg;
   logic               addr_hit;
   logic               oe_q;
   logic               valid_q;
   logic [BYTE_W-1:0]  data_q;

   i2c_wo_addr_match #(.BYTE_W(BYTE_W), .ADDR_PREFIX(ADDR_PREFIX)) u_match (
      .byte_i(shreg),
      .sel_i (sa0_i),
      .hit_o (addr_hit)
   );

   logic receiving;
   logic byte_done;
   assign receiving = (st == ST_ADDR) || (st == ST_DATA);
   assign byte_done = scl_fall_ev && (bit_cnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         bit_cnt <= '0;
         shreg   <= '0;
         oe_q    <= 1'b0;
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= 1'b0;
         if (stop_ev) begin
            st      <= ST_IDLE;
            oe_q    <= 1'b0;
            bit_cnt <= '0;
         end else if (start_ev) begin
            st      <= ST_ADDR;
            oe_q    <= 1'b0;
            bit_cnt <= '0;
         end else begin
            unique case (st)
               ST_ADDR, ST_DATA: begin
                  if (scl_rise_ev && (bit_cnt < LAST_BIT)) begin
                     shreg   <= {shreg[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 1'b1;
                  end else if (byte_done) begin
                     bit_cnt <= '0;
                     if (st == ST_ADDR) begin
                        if (addr_hit) begin
                           st   <= ST_ADDR_ACK;
                           oe_q <= 1'b1;
                        end else begin
                           st   <= ST_IGNORE;
                        end
                     end else begin
                        st      <= ST_DATA_ACK;
                        oe_q    <= 1'b1;
                        data_q  <= shreg;
                        valid_q <= 1'b1;
                     end
                  end
               end
               ST_ADDR_ACK, ST_DATA_ACK: begin
                  if (scl_fall_ev) begin
                     st   <= ST_DATA;
                     oe_q <= 1'b0;
                  end
               end
               ST_IGNORE, ST_IDLE: begin
                  st <= st;
               end
               default: begin
                  st   <= ST_IDLE;
                  oe_q <= 1'b0;
               end
            endcase
         end
      end
   end

   logic unused_recv;
   assign unused_recv = receiving;

   assign sda_oe_o   = oe_q;
   assign rx_valid_o = valid_q;
   assign rx_data_o  = data_q;

   // subaddress straps
   if (SUB_REG) begin : g_sub_reg
      logic [SUB_W-1:0] sub_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sub_q <= '0;
         else        sub_q <= strap_sub_i;
      end
      assign subaddr_o = sub_q;
   end else begin : g_sub_wire
      assign subaddr_o = strap_sub_i;
   end

endmodule

// File: rtl/i2c_wo_target_chk.sv
module i2c_wo_target_chk (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sda_oe,
   input logic                  rx_valid,
   input i2c_wo_pkg::wo_state_e st,
   input logic                  start_ev,
   input logic                  stop_ev,
   input logic                  scl_fall_ev
);
   import i2c_wo_pkg::*;

   assert_oe_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> (st == ST_ADDR_ACK || st == ST_DATA_ACK));

   assert_oe_starts_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(scl_fall_ev));

   assert_oe_ends_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> $past(scl_fall_ev || start_ev || stop_ev));

   assert_ignore_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGNORE) |-> (!sda_oe && !rx_valid));

   assert_valid_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_stop_idles_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (st == ST_IDLE && !sda_oe));

   assert_start_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_ev && !stop_ev) |=> (st == ST_ADDR && !sda_oe));

   assert_start_no_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_ev |=> !rx_valid);

endmodule

bind i2c_wo_target i2c_wo_target_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sda_oe     (sda_oe_o),
   .rx_valid   (rx_valid_o),
   .st         (st),
   .start_ev   (start_ev),
   .stop_ev    (stop_ev),
   .scl_fall_ev(scl_fall_ev)
);

// File: tb/tb_i2c_wo_target.sv
`timescale 1ns/1ps
module tb_i2c_wo_target;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       m_low = 1'b0;
   logic       sa0 = 1'b0;
   logic [2:0] straps = 3'b000;
   logic       sda_oe;
   logic [2:0] subaddr;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       sda_line;

   int checks = 0;
   int errors = 0;
   logic [7:0] rxq[$];

   assign sda_line = ~(m_low | sda_oe);

   always #10 clk = ~clk;

   i2c_wo_target dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl),
      .sda_i      (sda_line),
      .sda_oe_o   (sda_oe),
      .sa0_i      (sa0),
      .strap_sub_i(straps),
      .subaddr_o  (subaddr),
      .rx_data_o  (rx_data),
      .rx_valid_o (rx_valid)
   );

   always @(negedge clk) if (rx_valid) rxq.push_back(rx_data);

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit exp_ack(input logic [7:0] a, input logic s);
      return (a[7:1] == {6'b011100, s}) && !a[0];
   endfunction

   task automatic qwait();
      repeat (Q) @(negedge clk);
   endtask

   task automatic i2c_start();
      m_low = 1'b0; qwait();
      scl = 1'b1;   qwait();
      m_low = 1'b1; qwait();
      scl = 1'b0;   qwait();
   endtask

   task automatic i2c_stop();
      m_low = 1'b1; qwait();
      scl = 1'b1;   qwait();
      m_low = 1'b0; qwait();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         m_low = ~b[i]; qwait();
         scl = 1'b1;    qwait(); qwait();
         scl = 1'b0;    qwait();
      end
   endtask

   task automatic ack_slot(output bit acked);
      m_low = 1'b0; qwait();
      scl = 1'b1;   qwait();
      acked = (sda_line == 1'b0);
      qwait();
      scl = 1'b0;   qwait();
      check("R3 release after ack clock", int'(sda_oe), 0);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp, input string req);
      bit a;
      send_bits(b, 8);
      ack_slot(a);
      check(req, int'(a), int'(exp));
   endtask

   task automatic expect_rx(input logic [7:0] exp_q[$], input string req);
      check(req, rxq.size(), exp_q.size());
      if (rxq.size() == exp_q.size())
         foreach (exp_q[i]) check(req, int'(rxq[i]), int'(exp_q[i]));
      rxq.delete();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] eq[$];
      void'($urandom(32'h5EED1234));
      // R9 reset state
      repeat (3) @(negedge clk);
      check("R9 oe in reset", int'(sda_oe), 0);
      check("R9 valid in reset", int'(rx_valid), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R9 oe after reset", int'(sda_oe), 0);
      check("R9 valid after reset", int'(rx_valid), 0);

      // R8 subaddress passthrough
      for (int s = 0; s < 8; s++) begin
         straps = 3'(s); @(negedge clk);
         check("R8 subaddr", int'(subaddr), s);
      end

      // R1 / R5 directed, sa0 = 0
      sa0 = 1'b0;
      i2c_start();
      send_byte(8'h70, 1'b1, "R1 addr 0x70 sa0=0");
      send_byte(8'hA5, 1'b1, "R5 data ack");
      send_byte(8'h3C, 1'b1, "R5 data ack");
      i2c_stop();
      eq = '{8'hA5, 8'h3C}; expect_rx(eq, "R5 bytes");

      // R1 strap mismatch and match
      i2c_start();
      send_byte(8'h72, 1'b0, "R1 addr 0x72 sa0=0");
      send_byte(8'h11, 1'b0, "R4 ignored byte");
      i2c_stop();
      sa0 = 1'b1;
      i2c_start();
      send_byte(8'h72, 1'b1, "R1 addr 0x72 sa0=1");
      send_byte(8'hFF, 1'b1, "R5 data ack");
      i2c_stop();
      eq = '{8'hFF}; expect_rx(eq, "R4 R1 strap bytes");

      // R2 read address
      i2c_start();
      send_byte(8'h73, 1'b0, "R2 read addr");
      send_byte(8'h00, 1'b0, "R2 byte after read");
      i2c_stop();
      eq = '{}; expect_rx(eq, "R2 no output");

      // R4 / R6 repeated start: mismatch then match, match then read
      sa0 = 1'b0;
      i2c_start();
      send_byte(8'h5E, 1'b0, "R4 mismatch");
      send_byte(8'h42, 1'b0, "R4 silent");
      i2c_start();
      send_byte(8'h70, 1'b1, "R6 repeated start match");
      send_byte(8'h81, 1'b1, "R6 data after Sr");
      i2c_start();
      send_byte(8'h71, 1'b0, "R2 read after Sr");
      send_byte(8'h99, 1'b0, "R2 silent after Sr");
      i2c_stop();
      eq = '{8'h81}; expect_rx(eq, "R6 repeated start bytes");

      // R7 start mid-byte
      i2c_start();
      send_byte(8'h70, 1'b1, "R7 addr");
      send_bits(8'hC3, 5);
      i2c_start();
      send_byte(8'h70, 1'b1, "R7 readdress");
      send_byte(8'h5A, 1'b1, "R7 data");
      i2c_stop();
      eq = '{8'h5A}; expect_rx(eq, "R7 partial byte dropped");

      // random transfers
      for (int t = 0; t < 30; t++) begin
         logic [7:0] a;
         bit         ok;
         int         nb;
         sa0 = 1'($urandom);
         case ($urandom % 5)
            0: a = 8'h70;
            1: a = 8'h71;
            2: a = 8'h72;
            3: a = 8'h73;
            default: a = 8'($urandom);
         endcase
         ok = exp_ack(a, sa0);
         nb = 1 + ($urandom % 4);
         eq = '{};
         i2c_start();
         send_byte(a, ok, "R1 random addr");
         for (int k = 0; k < nb; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            send_byte(d, ok, "R5 random data ack");
            if (ok) eq.push_back(d);
         end
         i2c_stop();
         expect_rx(eq, "R5 random bytes");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule